// File: doc/BRIEF.md
# Write-Only I2C Converter Code Register Bank

This block is an I2C target that only accepts writes. It keeps twelve 8-bit code registers that feed an external digital-to-analog converter array. A fast system clock oversamples the bus lines. The block detects start and stop conditions and receives bytes most significant bit first. It acknowledges by enabling an open-drain pull-down on the data line.

Every write transaction carries three bytes: a target address with the direction bit, a channel selector byte, and a code byte. The address has a fixed upper pattern. Its three low bits are set by strap pins, so up to eight of these blocks can share one bus. The low nibble of the selector byte names the channel. The code byte is copied unchanged into that channel's register. In the same cycle, a one-cycle update pulse is raised for that channel only. Each transaction writes exactly one channel.

Top module: `i2c_code_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every code register becomes 0x00, `sda_oe_o` becomes 0 and `update_o` becomes all zeros.
- R2: Bits are counted in the order they are sent. The first four address bits must be 1,0,0,1. The next three must equal `cs_i[2]`, `cs_i[1]`, `cs_i[0]`. If any of these bits differ, the block acknowledges nothing in the transaction and changes no register.
- R3: If the eighth bit of the address byte (the direction bit) is 1, the address is not acknowledged and no register changes.
- R4: The low nibble of the selector byte (bits 3..0) selects the channel. A value n from 1 to 12 selects channel n, which is bits [8n-1:8n-8] of `code_o`. Bits 7..4 of the selector byte are ignored.
- R5: Selector values 0 and 13 to 15 are still acknowledged. The code byte that follows them is acknowledged but changes no register and raises no update pulse.
- R6: The code byte is received most significant bit first. It is stored unchanged. A register keeps its value unless it is written.
- R7: After each accepted byte, `sda_oe_o` is 1 for the whole ninth SCL high phase. It returns to 0 within a few system clocks after the ninth SCL falling edge.
- R8: A write raises the selected channel's `update_o` bit for exactly one clock, with at most one bit high at a time. Further bytes in the same transaction are not acknowledged and change nothing.
- R9: A repeated start restarts address reception. Only the selector and code bytes that follow it are used.
- R10: A stop before the code byte's acknowledge completes ends the transaction with no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| cs_i | input | 3 | Strap pins that give the low three address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| code_o | output | 96 | Twelve 8-bit code registers; channel n is in bits [8n-1:8n-8] |
| update_o | output | 12 | One-cycle write pulse per channel; bit n-1 belongs to channel n |

## Verification
If the protocol state machine is wrong, the first sign appears at the ninth clock of the affected byte. `sda_oe_o` is then missing, comes early, or stays on past that pulse. This shows within one bus bit time of the fault. If the channel decode or the shift register is wrong, the wrong field of `code_o` changes, or a wrong value lands in the right field. The matching `update_o` pulse appears a few system clocks after the last acknowledge. A missing or extra pulse on another bit points to a fault in the write-enable path. If state survives a stop or a repeated start when it should not, a later transaction writes a channel it never named.

// File: rtl/icb_pkg.sv
package icb_pkg;

   // protocol engine states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_SKIP
   } bus_state_t;

   // conditioned view of one bus line
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } line_ev_t;

endpackage

// File: rtl/icb_line_sync.sv
module icb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output icb_pkg::line_ev_t ev_o
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("icb_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   // idle bus level is high, so reset to high to avoid false edges
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= {STAGES{1'b1}};
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         prev_q  <= chain_q[LAST];
      end
   end

   always_comb begin
      ev_o.level = chain_q[LAST];
      ev_o.rise  = chain_q[LAST] & ~prev_q;
      ev_o.fall  = ~chain_q[LAST] & prev_q;
   end

endmodule

// File: rtl/icb_proto_engine.sv
module icb_proto_engine #(
   parameter int          PREFIX_W = 4,
   parameter logic [3:0]  PREFIX   = 4'b1001,
   parameter int          SEL_W    = 3,
   parameter int          BYTE_W   = 8,
   parameter int          SUB_W    = 4,
   parameter int          NUM_CH   = 12,
   localparam int         IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  icb_pkg::line_ev_t scl_ev,
   input  icb_pkg::line_ev_t sda_ev,
   input  logic [SEL_W-1:0]  sel_pins,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data
);
   import icb_pkg::*;

   localparam int               ADDR_W   = PREFIX_W + SEL_W;
   localparam int               CNT_W    = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
   localparam logic [SUB_W-1:0] TOP_SEL  = SUB_W'(NUM_CH);

   generate
      if (ADDR_W + 1 != BYTE_W) begin : g_bad_addr
         $error("icb_proto_engine: address plus direction bit must fill one byte");
      end
      if (SUB_W > BYTE_W) begin : g_bad_sub
         $error("icb_proto_engine: selector field wider than a byte");
      end
      if (NUM_CH >= (1 << SUB_W)) begin : g_bad_ch
         $error("icb_proto_engine: selector field too narrow for channel count");
      end
   endgenerate

   bus_state_t          state_q;
   logic [BYTE_W-1:0]   shreg_q;
   logic [CNT_W-1:0]    bitcnt_q;
   logic [SUB_W-1:0]    sub_q;
   logic [BYTE_W-1:0]   data_q;

   logic start_c, stop_c, byte_end_c, addr_ok_c, is_read_c, sub_valid_c;

   // line conditions: SDA moves while SCL stays high
   assign start_c    = scl_ev.level & ~scl_ev.rise & sda_ev.fall;
   assign stop_c     = scl_ev.level & ~scl_ev.rise & sda_ev.rise;
   assign byte_end_c = scl_ev.fall & (bitcnt_q == FULL_CNT);

   // address byte layout: prefix, strap bits, direction
   assign addr_ok_c  = (shreg_q[BYTE_W-1 -: PREFIX_W] == PREFIX[PREFIX_W-1:0]) &&
                       (shreg_q[SEL_W:1] == sel_pins);
   assign is_read_c  = shreg_q[0];
   assign sub_valid_c = (sub_q != '0) && (sub_q <= TOP_SEL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         shreg_q  <= '0;
         bitcnt_q <= '0;
         sub_q    <= '0;
         data_q   <= '0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_c) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            sda_oe   <= 1'b0;
         end else if (stop_c) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            sda_oe   <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR, ST_SUB, ST_DATA: begin
                  if (scl_ev.rise && bitcnt_q != FULL_CNT) begin
                     shreg_q  <= {shreg_q[BYTE_W-2:0], sda_ev.level};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (byte_end_c) begin
                     bitcnt_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (addr_ok_c && !is_read_c) begin
                           state_q <= ST_ADDR_ACK;
                           sda_oe  <= 1'b1;
                        end else begin
                           state_q <= ST_SKIP;
                        end
                     end else if (state_q == ST_SUB) begin
                        sub_q   <= shreg_q[SUB_W-1:0];
                        state_q <= ST_SUB_ACK;
                        sda_oe  <= 1'b1;
                     end else begin
                        data_q  <= shreg_q;
                        state_q <= ST_DATA_ACK;
                        sda_oe  <= 1'b1;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_ev.fall) begin
                     sda_oe  <= 1'b0;
                     state_q <= ST_SUB;
                  end
               end
               ST_SUB_ACK: begin
                  if (scl_ev.fall) begin
                     sda_oe  <= 1'b0;
                     state_q <= ST_DATA;
                  end
               end
               ST_DATA_ACK: begin
                  if (scl_ev.fall) begin
                     sda_oe  <= 1'b0;
                     state_q <= ST_SKIP;
                     wr_en   <= sub_valid_c;
                     wr_idx  <= IDX_W'(sub_q - SUB_W'(1));
                     wr_data <= data_q;
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

   // R7: acknowledge drive ends at the falling edge closing the ninth pulse
   p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && scl_ev.fall && !start_c && !stop_c) |=> !sda_oe);

   // R7: acknowledge only driven from an acknowledge state
   p_ack_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (state_q == ST_ADDR_ACK || state_q == ST_SUB_ACK ||
                  state_q == ST_DATA_ACK));

   // R3: a read request never gets an acknowledge
   p_no_read_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && byte_end_c && is_read_c && !start_c && !stop_c)
      |=> !sda_oe);

   // R9: a start condition always restarts address reception
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> (state_q == ST_ADDR && bitcnt_q == '0));

   // R10: a stop returns to idle and releases the line
   p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_c && !start_c) |=> (state_q == ST_IDLE && !sda_oe));

   // R8: a write follows only the code byte acknowledge, never twice in a row
   p_write_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(state_q) == ST_DATA_ACK));
   p_write_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/icb_latch_bank.sv
module icb_latch_bank #(
   parameter int  NUM_CH = 12,
   parameter int  CODE_W = 8,
   localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [CODE_W-1:0]        wr_data,
   output logic [NUM_CH*CODE_W-1:0] codes,
   output logic [NUM_CH-1:0]        upd
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("icb_latch_bank: need at least one channel");
      end
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit;
         assign hit = wr_en && (wr_idx == IDX_W'(c));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               codes[c*CODE_W +: CODE_W] <= '0;
               upd[c]                    <= 1'b0;
            end else begin
               upd[c] <= hit;
               if (hit) codes[c*CODE_W +: CODE_W] <= wr_data;
            end
         end
      end
   endgenerate

   // R8: at most one channel pulses at a time
   p_upd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd));

   // R5: the engine never hands an index past the last channel
   p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NUM_CH));

   // R6: registers hold when no write is requested
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(codes));

endmodule

// File: rtl/i2c_code_bank.sv
module i2c_code_bank #(
   parameter int         NUM_CH      = 12,
   parameter int         CODE_W      = 8,
   parameter int         SEL_W       = 3,
   parameter int         SUB_W       = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] PREFIX      = 4'b1001,
   localparam int        PREFIX_W    = CODE_W - 1 - SEL_W,
   localparam int        IDX_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_i,
   input  logic                     sda_i,
   input  logic [SEL_W-1:0]         cs_i,
   output logic                     sda_oe_o,
   output logic [NUM_CH*CODE_W-1:0] code_o,
   output logic [NUM_CH-1:0]        update_o
);
   import icb_pkg::*;

   generate
      if (PREFIX_W != 4) begin : g_bad_prefix
         $error("i2c_code_bank: fixed prefix must be four bits wide");
      end
   endgenerate

   line_ev_t          scl_ev, sda_ev;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [CODE_W-1:0] wr_data;

   icb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .ev_o(scl_ev));

   icb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .ev_o(sda_ev));

   icb_proto_engine #(
      .PREFIX_W(4), .PREFIX(PREFIX), .SEL_W(SEL_W), .BYTE_W(CODE_W),
      .SUB_W(SUB_W), .NUM_CH(NUM_CH)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_ev(scl_ev), .sda_ev(sda_ev),
      .sel_pins(cs_i), .sda_oe(sda_oe_o), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data));

   icb_latch_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .codes(code_o), .upd(update_o));

endmodule

// File: tb/sim_i2c_code_bank.sv
module sim_i2c_code_bank;
   localparam int CLK_NS = 10;
   localparam int HALF   = 25;
   localparam int NCH    = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  cs = 3'b101;
   logic        sda_oe;
   logic [NCH*8-1:0] code;
   logic [NCH-1:0]   upd;
   wire         sda_line = sda_m & ~sda_oe;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [7:0] exp_code [NCH];
   int strobe_cnt [NCH];
   int multi_cnt = 0;
   logic [NCH-1:0] upd_prev = '0;
   int long_cnt = 0;

   always #(CLK_NS/2) clk = ~clk;

   i2c_code_bank u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .cs_i(cs),
      .sda_oe_o(sda_oe), .code_o(code), .update_o(upd));

   always @(posedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) if (upd[c]) strobe_cnt[c]++;
         if ($countones(upd) > 1) multi_cnt++;
         if ((upd & upd_prev) != '0) long_cnt++;
      end
      upd_prev <= upd;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(HALF);
      scl_m = 1'b1; wait_clk(HALF);
      sda_m = 1'b0; wait_clk(HALF);
      scl_m = 1'b0; wait_clk(8);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(HALF);
      scl_m = 1'b1; wait_clk(HALF);
      sda_m = 1'b1; wait_clk(HALF);
   endtask

   // sends one byte, returns ack seen and whether the line was freed after it
   task automatic send_byte(input logic [7:0] b, output bit ack, output bit freed);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_clk(HALF);
         scl_m = 1'b1; wait_clk(HALF);
         scl_m = 1'b0; wait_clk(8);
      end
      sda_m = 1'b1; wait_clk(HALF);
      scl_m = 1'b1; wait_clk(HALF/2);
      ack = (sda_line == 1'b0);
      wait_clk(HALF - HALF/2);
      scl_m = 1'b0; wait_clk(8);
      freed = (sda_oe == 1'b0);
   endtask

   function automatic logic [7:0] addr_byte(input logic [2:0] pins, input bit rd);
      return {4'b1001, pins, rd};
   endfunction

   function automatic logic [7:0] chan(input int n);
      return code[(n-1)*8 +: 8];
   endfunction

   task automatic write_txn(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                            output bit [2:0] acks, output bit [2:0] frees);
      bit k, f;
      bus_start();
      send_byte(a, k, f); acks[2] = k; frees[2] = f;
      send_byte(s, k, f); acks[1] = k; frees[1] = f;
      send_byte(d, k, f); acks[0] = k; frees[0] = f;
      bus_stop();
      wait_clk(10);
   endtask

   task automatic check_all(input string tag);
      for (int n = 1; n <= NCH; n++)
         check(chan(n) == exp_code[n-1], tag, chan(n), exp_code[n-1]);
   endtask

   task automatic total_strobes(output int t);
      t = 0;
      for (int c = 0; c < NCH; c++) t += strobe_cnt[c];
   endtask

   task automatic t_reset();
      check(code == '0, "R1 codes after reset", 0, 0);
      check(sda_oe == 1'b0, "R1 ack idle after reset", int'(sda_oe), 0);
      check(upd == '0, "R1 no strobe after reset", int'(upd), 0);
   endtask

   task automatic t_basic();
      bit [2:0] a, f;
      int t0, t1;
      total_strobes(t0);
      write_txn(addr_byte(cs, 0), 8'h01, 8'hA5, a, f);
      exp_code[0] = 8'hA5;
      check(a == 3'b111, "R2 matching address acked on all bytes", a, 7);
      check(f == 3'b111, "R7 line released after each ack", f, 7);
      check(chan(1) == 8'hA5, "R6 channel 1 stored", chan(1), 8'hA5);
      check(strobe_cnt[0] == 1, "R8 one strobe on channel 1", strobe_cnt[0], 1);
      total_strobes(t1);
      check(t1 - t0 == 1, "R8 one strobe in total", t1 - t0, 1);
   endtask

   task automatic t_all_channels();
      bit [2:0] a, f;
      for (int n = 1; n <= NCH; n++) begin
         logic [7:0] v = 8'(n * 37 + 11);
         logic [7:0] s = {4'(n * 5 + 3), 4'(n)};
         write_txn(addr_byte(cs, 0), s, v, a, f);
         exp_code[n-1] = v;
         check(a == 3'b111, "R4 selector acked", a, 7);
      end
      check_all("R4 each channel holds its own code");
      check(multi_cnt == 0, "R8 never two strobes at once", multi_cnt, 0);
      check(long_cnt == 0, "R8 strobes last one cycle", long_cnt, 0);
   endtask

   task automatic t_msb_first();
      bit [2:0] a, f;
      write_txn(addr_byte(cs, 0), 8'h07, 8'h80, a, f);
      exp_code[6] = 8'h80;
      check(chan(7) == 8'h80, "R6 msb first 0x80", chan(7), 8'h80);
      write_txn(addr_byte(cs, 0), 8'h08, 8'h01, a, f);
      exp_code[7] = 8'h01;
      check(chan(8) == 8'h01, "R6 msb first 0x01", chan(8), 8'h01);
   endtask

   task automatic t_invalid_sel();
      bit [2:0] a, f;
      int t0, t1;
      logic [3:0] bad [4] = '{4'h0, 4'hD, 4'hE, 4'hF};
      total_strobes(t0);
      for (int i = 0; i < 4; i++) begin
         write_txn(addr_byte(cs, 0), {4'h2, bad[i]}, 8'h5A, a, f);
         check(a == 3'b111, "R5 out of range selector still acked", a, 7);
      end
      total_strobes(t1);
      check(t1 == t0, "R5 no strobe for out of range selector", t1 - t0, 0);
      check_all("R5 out of range selector changes nothing");
   endtask

   task automatic t_addr_miss();
      bit [2:0] a, f;
      int t0, t1;
      total_strobes(t0);
      write_txn(addr_byte(cs ^ 3'b010, 0), 8'h02, 8'h33, a, f);
      check(a == 3'b000, "R2 strap mismatch not acked", a, 0);
      write_txn({4'b1000, cs, 1'b0}, 8'h02, 8'h33, a, f);
      check(a == 3'b000, "R2 prefix mismatch not acked", a, 0);
      write_txn(addr_byte(cs, 1), 8'h02, 8'h33, a, f);
      check(a == 3'b000, "R3 read direction not acked", a, 0);
      total_strobes(t1);
      check(t1 == t0, "R2 no strobe for unaddressed transfers", t1 - t0, 0);
      check_all("R3 unaddressed transfers change nothing");
      // new strap setting is honoured
      cs = 3'b010;
      wait_clk(4);
      write_txn(addr_byte(3'b010, 0), 8'h0C, 8'hC3, a, f);
      exp_code[11] = 8'hC3;
      check(a == 3'b111 && chan(12) == 8'hC3, "R2 new strap value accepted", chan(12), 8'hC3);
   endtask

   task automatic t_restart();
      bit k, f;
      bus_start();
      send_byte(addr_byte(cs, 0), k, f);
      send_byte(8'h03, k, f);
      bus_start();
      send_byte(addr_byte(cs, 0), k, f);
      check(k, "R9 address acked after repeated start", int'(k), 1);
      send_byte(8'h04, k, f);
      send_byte(8'h44, k, f);
      bus_stop();
      wait_clk(10);
      exp_code[3] = 8'h44;
      check(chan(4) == 8'h44, "R9 channel after repeated start written", chan(4), 8'h44);
      check(chan(3) == exp_code[2], "R9 abandoned channel untouched", chan(3), exp_code[2]);
   endtask

   task automatic t_stop_mid();
      bit k, f;
      int t0, t1;
      total_strobes(t0);
      bus_start();
      send_byte(addr_byte(cs, 0), k, f);
      send_byte(8'h05, k, f);
      bus_stop();
      wait_clk(10);
      total_strobes(t1);
      check(t1 == t0, "R10 stop before code byte gives no strobe", t1 - t0, 0);
      check_all("R10 stop before code byte changes nothing");
   endtask

   task automatic t_extra_byte();
      bit k, f;
      int t0, t1;
      total_strobes(t0);
      bus_start();
      send_byte(addr_byte(cs, 0), k, f);
      send_byte(8'h09, k, f);
      send_byte(8'h99, k, f);
      send_byte(8'h66, k, f);
      check(!k, "R8 byte after code byte not acked", int'(k), 0);
      bus_stop();
      wait_clk(10);
      exp_code[8] = 8'h99;
      total_strobes(t1);
      check(t1 - t0 == 1, "R8 single write per transaction", t1 - t0, 1);
      check(chan(9) == 8'h99, "R8 extra byte not stored", chan(9), 8'h99);
   endtask

   task automatic t_reset_again();
      wait_clk(2);
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(3);
      for (int c = 0; c < NCH; c++) exp_code[c] = 8'h00;
      check(code == '0, "R1 reset clears written codes", 0, 0);
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) begin exp_code[c] = 8'h00; strobe_cnt[c] = 0; end
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_basic();
      t_all_channels();
      t_msb_first();
      t_invalid_sel();
      t_addr_miss();
      t_restart();
      t_stop_mid();
      t_extra_byte();
      t_reset_again();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule